// File: doc/BRIEF.md
# Serial Memory-Panel Receiver

This block is the panel end of a three-wire serial link (clock, data, select) that drives a 96 by 96 monochrome display whose pixels each hold one bit of memory. It can serve as a checker next to a display controller, or as an emulation stand-in for the panel. The serial wires and the inversion pin are brought into the system clock domain. Each frame is decoded into one of three operations: write lines, clear the screen, or hold. The result is kept in a one-bit pixel array, which the chip reads through a combinational port.

The block also tracks the polarity of the common electrode. A strap input picks the source of that polarity. In software mode it comes from a bit in every frame header. In external mode it comes from the rising edges of a dedicated pin, and the new value is applied only while select is low. A display-enable input blanks the read port to white and leaves the stored picture untouched. Two flags report protocol faults in the current frame: a bad line address, and a line cut short.

Top module: `mlcd_panel_rx`

## Requirements
- R1: After reset every pixel reads 1 (white), `vcom` is 0, and both error flags are 0.
- R2: Edges of `ser_clk` while `ser_sel` is low have no effect. A frame begins when `ser_sel` rises, and data bits are taken on rising edges of `ser_clk` while `ser_sel` is high.
- R3: The first three bits of a frame are the mode bits, in this order: write bit, polarity bit, clear bit. Five ignored bits follow them. A write bit of 1 together with a clear bit of 0 selects line-write mode for the rest of the frame.
- R4: In line-write mode the frame is a sequence of 112-bit records. Each record holds a 7-bit line address sent least significant bit first, one ignored bit, 96 pixel bits, then 8 ignored bits. Address k selects read row k-1. The first pixel bit lands in column 0 and the last in column 95.
- R5: A complete line is held in a holding latch. It is written to the pixel array only when the first bit of the next record is taken, or when `ser_sel` falls. Until then the row keeps its old contents.
- R6: A clear bit of 1 sets every pixel to 1, whatever the write bit is.
- R7: A frame with both the write bit and the clear bit at 0 leaves every pixel unchanged.
- R8: A line address of 0 or greater than 96 sets `addr_err`, and that record's pixels are discarded. Later records in the same frame are still accepted. Both error flags return to 0 when the next frame begins.
- R9: If `ser_sel` falls after at least one pixel bit of a record but before its 96th, `trunc_err` is set and that line is discarded.
- R10: With `strap_ext` at 0, `vcom` takes the polarity bit of the most recent frame once the third mode bit has been taken. It does not change while select is low.
- R11: With `strap_ext` at 1, an armed bit toggles on each rising edge of `inv_pin`. `vcom` copies the armed bit while select is low and holds its value while select is high. The polarity bit in the frame header is ignored.
- R12: While `disp_en` is 0, `rd_pix` reads 1 and the stored pixels are kept. Rising edges of `inv_pin` in this state do not toggle the armed bit.
- R13: `rd_pix` returns the stored pixel at `rd_row`, `rd_col` (1 means white). A row of 96 or more, or a column of 96 or more, reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_dat | input | 1 | Serial data from the host |
| ser_sel | input | 1 | Frame select, high during a frame |
| inv_pin | input | 1 | External polarity-inversion pin |
| strap_ext | input | 1 | Polarity source: 1 external pin, 0 header bit |
| disp_en | input | 1 | Display enable, 0 blanks to white |
| rd_row | input | 7 | Read row index (0 to 95) |
| rd_col | input | 7 | Read column index (0 to 95) |
| rd_pix | output | 1 | Pixel value at the read address |
| vcom | output | 1 | Current common-electrode polarity |
| addr_err | output | 1 | Bad line address seen in this frame |
| trunc_err | output | 1 | Line cut short at the end of this frame |

## Verification
The checker watches four things on every cycle. It checks that the blanked read port shows white. It checks that `vcom` holds while select is high in external mode, and while select stays low in software mode. It checks that both flags are clear just after each frame start, and that `trunc_err` rises only just after select has fallen. The bench's scenarios have to show the rest, since each depends on a whole serial frame. That covers the record layout and bit order, and the deferred commit of the holding latch. It also covers that bad and truncated lines are discarded, that clear and hold frames act on the whole array, and that clock edges outside a frame are ignored.

// File: rtl/mlcd_pkg.sv
package mlcd_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_ADDR,
        PH_GAP,
        PH_DATA,
        PH_TAIL,
        PH_SKIP
    } rx_phase_e;

    localparam int MODE_WR_POS  = 0;
    localparam int MODE_POL_POS = 1;
    localparam int MODE_CLR_POS = 2;
endpackage

// File: rtl/mlcd_sync.sv
module mlcd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mlcd_frame_rx.sv
module mlcd_frame_rx
    import mlcd_pkg::*;
#(
    parameter int COLS      = 96,
    parameter int ROWS      = 96,
    parameter int ADDR_BITS = 7,
    parameter int HDR_BITS  = 8,
    parameter int TAIL_BITS = 8,
    localparam int RW       = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic            bit_stb_i,
    input  logic            bit_i,
    output logic            wr_en_o,
    output logic [RW-1:0]   wr_row_o,
    output logic [COLS-1:0] wr_data_o,
    output logic            clr_o,
    output logic            m1_stb_o,
    output logic            m1_o,
    output logic            addr_err_o,
    output logic            trunc_err_o
);
    localparam int CW = $clog2(COLS + HDR_BITS + TAIL_BITS + ADDR_BITS);
    localparam logic [CW-1:0] LAST_DATA = CW'(COLS - 1);
    localparam logic [CW-1:0] LAST_HDR  = CW'(HDR_BITS - 1);
    localparam logic [CW-1:0] LAST_TAIL = CW'(TAIL_BITS - 1);
    localparam logic [CW-1:0] LAST_ADDR = CW'(ADDR_BITS - 1);
    localparam logic [CW-1:0] POS_WR    = CW'(MODE_WR_POS);
    localparam logic [CW-1:0] POS_POL   = CW'(MODE_POL_POS);
    localparam logic [CW-1:0] POS_CLR   = CW'(MODE_CLR_POS);
    localparam logic [ADDR_BITS-1:0] MAX_ADDR = ADDR_BITS'(ROWS);

    typedef struct packed {
        rx_phase_e             ph;
        logic [CW-1:0]         cnt;
        logic                  wr_mode;
        logic                  dyn;
        logic [ADDR_BITS-1:0]  addr;
        logic                  addr_ok;
        logic [COLS-1:0]       line;
        logic                  pend;
        logic [RW-1:0]         prow;
        logic [COLS-1:0]       pdata;
        logic                  sel_prev;
        logic                  wr_en;
        logic [RW-1:0]         wr_row;
        logic [COLS-1:0]       wr_data;
        logic                  clr;
        logic                  m1_stb;
        logic                  m1;
        logic                  addr_err;
        logic                  trunc;
    } rx_state_t;

    rx_state_t s_q, s_d;
    logic [ADDR_BITS-1:0] full_addr;
    logic [COLS-1:0]      line_nx;

    always_comb begin
        s_d          = s_q;
        s_d.wr_en    = 1'b0;
        s_d.clr      = 1'b0;
        s_d.m1_stb   = 1'b0;
        s_d.sel_prev = sel_i;
        full_addr    = {bit_i, s_q.addr[ADDR_BITS-1:1]};
        line_nx      = s_q.line;
        line_nx[s_q.cnt] = bit_i;

        if (sel_i && !s_q.sel_prev) begin
            s_d.ph       = PH_HDR;
            s_d.cnt      = '0;
            s_d.wr_mode  = 1'b0;
            s_d.dyn      = 1'b0;
            s_d.pend     = 1'b0;
            s_d.addr_err = 1'b0;
            s_d.trunc    = 1'b0;
        end else if (!sel_i && s_q.sel_prev) begin
            if (s_q.pend) begin
                s_d.wr_en   = 1'b1;
                s_d.wr_row  = s_q.prow;
                s_d.wr_data = s_q.pdata;
                s_d.pend    = 1'b0;
            end
            if (s_q.ph == PH_DATA && s_q.cnt != '0) s_d.trunc = 1'b1;
            s_d.ph = PH_IDLE;
        end else if (sel_i && bit_stb_i) begin
            unique case (s_q.ph)
                PH_HDR: begin
                    if (s_q.cnt == POS_WR)  s_d.wr_mode = bit_i;
                    if (s_q.cnt == POS_POL) s_d.m1 = bit_i;
                    if (s_q.cnt == POS_CLR) begin
                        s_d.m1_stb = 1'b1;
                        s_d.clr    = bit_i;
                        s_d.dyn    = s_q.wr_mode && !bit_i;
                    end
                    if (s_q.cnt == LAST_HDR) begin
                        s_d.ph  = s_d.dyn ? PH_ADDR : PH_SKIP;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (s_q.cnt == '0 && s_q.pend) begin
                        s_d.wr_en   = 1'b1;
                        s_d.wr_row  = s_q.prow;
                        s_d.wr_data = s_q.pdata;
                        s_d.pend    = 1'b0;
                    end
                    s_d.addr = full_addr;
                    if (s_q.cnt == LAST_ADDR) begin
                        s_d.addr_ok = (full_addr != '0) && (full_addr <= MAX_ADDR);
                        if (!s_d.addr_ok) s_d.addr_err = 1'b1;
                        s_d.ph  = PH_GAP;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    s_d.ph  = PH_DATA;
                    s_d.cnt = '0;
                end
                PH_DATA: begin
                    s_d.line = line_nx;
                    if (s_q.cnt == LAST_DATA) begin
                        if (s_q.addr_ok) begin
                            s_d.pend  = 1'b1;
                            s_d.prow  = RW'(s_q.addr - 1'b1);
                            s_d.pdata = line_nx;
                        end
                        s_d.ph  = PH_TAIL;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (s_q.cnt == LAST_TAIL) begin
                        s_d.ph  = PH_ADDR;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en_o     = s_q.wr_en;
    assign wr_row_o    = s_q.wr_row;
    assign wr_data_o   = s_q.wr_data;
    assign clr_o       = s_q.clr;
    assign m1_stb_o    = s_q.m1_stb;
    assign m1_o        = s_q.m1;
    assign addr_err_o  = s_q.addr_err;
    assign trunc_err_o = s_q.trunc;
endmodule

// File: rtl/mlcd_pixel_mem.sv
module mlcd_pixel_mem #(
    parameter int COLS = 96,
    parameter int ROWS = 96,
    localparam int RW  = $clog2(ROWS),
    localparam int CLW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [RW-1:0]   wr_row_i,
    input  logic [COLS-1:0] wr_data_i,
    input  logic            clr_i,
    input  logic [RW-1:0]   rd_row_i,
    input  logic [CLW-1:0]  rd_col_i,
    output logic            rd_bit_o
);
    localparam logic [RW-1:0]  ROW_LIM = RW'(ROWS);
    localparam logic [CLW-1:0] COL_LIM = CLW'(COLS);

    logic [COLS-1:0] mem_q [ROWS];
    logic [COLS-1:0] mem_d [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) mem_d[r] = mem_q[r];
        if (clr_i) begin
            for (int r = 0; r < ROWS; r++) mem_d[r] = '1;
        end else if (wr_en_i && wr_row_i < ROW_LIM) begin
            mem_d[wr_row_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '1;
        end else begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= mem_d[r];
        end
    end

    always_comb begin
        if (rd_row_i < ROW_LIM && rd_col_i < COL_LIM) rd_bit_o = mem_q[rd_row_i][rd_col_i];
        else                                          rd_bit_o = 1'b1;
    end
endmodule

// File: rtl/mlcd_vcom.sv
module mlcd_vcom (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode_i,
    input  logic sel_i,
    input  logic inv_rise_i,
    input  logic disp_en_i,
    input  logic m1_stb_i,
    input  logic m1_i,
    output logic vcom_o
);
    typedef struct packed {
        logic armed;
        logic vcom;
    } pol_t;

    pol_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (ext_mode_i && disp_en_i && inv_rise_i) p_d.armed = !p_q.armed;
        if (ext_mode_i) begin
            if (!sel_i) p_d.vcom = p_q.armed;
        end else if (m1_stb_i) begin
            p_d.vcom = m1_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign vcom_o = p_q.vcom;
endmodule

// File: rtl/mlcd_panel_rx.sv
module mlcd_panel_rx #(
    parameter int COLS        = 96,
    parameter int ROWS        = 96,
    parameter int SYNC_STAGES = 2,
    localparam int RW         = $clog2(ROWS),
    localparam int CLW        = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_sel,
    input  logic           inv_pin,
    input  logic           strap_ext,
    input  logic           disp_en,
    input  logic [RW-1:0]  rd_row,
    input  logic [CLW-1:0] rd_col,
    output logic           rd_pix,
    output logic           vcom,
    output logic           addr_err,
    output logic           trunc_err
);
    typedef struct packed {
        logic sclk_prev;
        logic inv_prev;
    } edge_t;

    logic [3:0]      sync_v;
    logic            sclk_s, dat_s, sel_s, inv_s;
    edge_t           e_q, e_d;
    logic            bit_stb, inv_rise;
    logic            wr_en, clr, m1_stb, m1;
    logic [RW-1:0]   wr_row;
    logic [COLS-1:0] wr_data;
    logic            stored_pix;

    mlcd_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk, ser_dat, ser_sel, inv_pin}),
        .sync_o  (sync_v)
    );
    assign {sclk_s, dat_s, sel_s, inv_s} = sync_v;

    always_comb begin
        e_d.sclk_prev = sclk_s;
        e_d.inv_prev  = inv_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign bit_stb  = sclk_s && !e_q.sclk_prev;
    assign inv_rise = inv_s && !e_q.inv_prev;

    mlcd_frame_rx #(.COLS(COLS), .ROWS(ROWS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_s),
        .bit_stb_i   (bit_stb),
        .bit_i       (dat_s),
        .wr_en_o     (wr_en),
        .wr_row_o    (wr_row),
        .wr_data_o   (wr_data),
        .clr_o       (clr),
        .m1_stb_o    (m1_stb),
        .m1_o        (m1),
        .addr_err_o  (addr_err),
        .trunc_err_o (trunc_err)
    );

    mlcd_pixel_mem #(.COLS(COLS), .ROWS(ROWS)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_row_i  (wr_row),
        .wr_data_i (wr_data),
        .clr_i     (clr),
        .rd_row_i  (rd_row),
        .rd_col_i  (rd_col),
        .rd_bit_o  (stored_pix)
    );

    mlcd_vcom u_vcom (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode_i (strap_ext),
        .sel_i      (sel_s),
        .inv_rise_i (inv_rise),
        .disp_en_i  (disp_en),
        .m1_stb_i   (m1_stb),
        .m1_i       (m1),
        .vcom_o     (vcom)
    );

    assign rd_pix = disp_en ? stored_pix : 1'b1;
endmodule

// File: rtl/mlcd_panel_rx_chk.sv
module mlcd_panel_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_s,
    input logic strap_ext,
    input logic disp_en,
    input logic rd_pix,
    input logic vcom,
    input logic addr_err,
    input logic trunc_err
);
    assert_blank_white_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> rd_pix);

    assert_ext_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_ext && sel_s) |=> $stable(vcom));

    assert_sw_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_ext && !sel_s && !$past(sel_s)) |=> $stable(vcom));

    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_s) |=> (!addr_err && !trunc_err));

    assert_trunc_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trunc_err) |-> ($past(sel_s, 2) && !$past(sel_s)));
endmodule

bind mlcd_panel_rx mlcd_panel_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .strap_ext (strap_ext),
    .disp_en   (disp_en),
    .rd_pix    (rd_pix),
    .vcom      (vcom),
    .addr_err  (addr_err),
    .trunc_err (trunc_err)
);

// File: tb/tb_mlcd_panel_rx.sv
module tb_mlcd_panel_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 8;
    // {line address, pattern seed}; polarity bit of each frame is seed[0]
    localparam logic [14:0] VEC [NVEC] = '{
        {7'd1,  8'd17}, {7'd96, 8'd42}, {7'd2,  8'd5},  {7'd48, 8'd200},
        {7'd95, 8'd77}, {7'd50, 8'd128}, {7'd1, 8'd9},  {7'd33, 8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel = 1'b0, inv_pin = 1'b0;
    logic strap_ext = 1'b0, disp_en = 1'b1;
    logic [6:0] rd_row = '0, rd_col = '0;
    logic rd_pix, vcom, addr_err, trunc_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [95:0] shadow [96];

    mlcd_panel_rx dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_sel(ser_sel), .inv_pin(inv_pin), .strap_ext(strap_ext),
        .disp_en(disp_en), .rd_row(rd_row), .rd_col(rd_col), .rd_pix(rd_pix),
        .vcom(vcom), .addr_err(addr_err), .trunc_err(trunc_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic pat(input logic [7:0] seed, input int c);
        return ((c * 5 + int'(seed)) % 7) < 3;
    endfunction

    function automatic int zcol(input logic [7:0] seed);
        for (int c = 0; c < 96; c++) if (!pat(seed, c)) return c;
        return 0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int row, input int col, output logic v);
        rd_row = 7'(row);
        rd_col = 7'(col);
        #1;
        v = rd_pix;
    endtask

    task automatic chk_pix(input string req, input int row, input int col, input logic exp);
        logic v;
        rd(row, col, v);
        chk(req, v, exp);
    endtask

    task automatic sbit(input logic b);
        ser_dat = b;
        tick(HALF_BIT);
        ser_clk = 1'b1;
        tick(HALF_BIT);
        ser_clk = 1'b0;
    endtask

    task automatic hdr(input logic m0, input logic m1, input logic m2);
        sbit(m0); sbit(m1); sbit(m2);
        for (int i = 0; i < 5; i++) sbit(1'b0);
    endtask

    task automatic rec_part(input logic [6:0] addr, input logic [7:0] seed, input int ndata);
        for (int i = 0; i < 7; i++) sbit(addr[i]);
        sbit(1'b0);
        for (int c = 0; c < ndata; c++) sbit(pat(seed, c));
    endtask

    task automatic rec(input logic [6:0] addr, input logic [7:0] seed);
        rec_part(addr, seed, 96);
        for (int i = 0; i < 8; i++) sbit(1'b0);
    endtask

    task automatic shadow_write(input int addr, input logic [7:0] seed);
        for (int c = 0; c < 96; c++) shadow[addr-1][c] = pat(seed, c);
    endtask

    task automatic sel_up;
        ser_sel = 1'b1;
        tick(6);
    endtask

    task automatic sel_dn;
        tick(6);
        ser_sel = 1'b0;
        tick(12);
    endtask

    task automatic inv_pulse;
        inv_pin = 1'b1;
        tick(8);
        inv_pin = 1'b0;
        tick(8);
    endtask

    task automatic static_frame(input logic m1);
        sel_up;
        hdr(1'b0, m1, 1'b0);
        sel_dn;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int zc, zc2;
        logic [6:0] a;
        logic [7:0] sd;
        for (int r = 0; r < 96; r++) shadow[r] = '1;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        chk_pix("R1 pixel 0,0", 0, 0, 1'b1);
        chk_pix("R1 pixel 95,95", 95, 95, 1'b1);
        chk("R1 vcom", vcom, 1'b0);
        chk("R1 addr_err", addr_err, 1'b0);
        chk("R1 trunc_err", trunc_err, 1'b0);

        // R3 R4 R10 R13: vector table, one single-line frame per entry
        for (int i = 0; i < NVEC; i++) begin
            a  = VEC[i][14:8];
            sd = VEC[i][7:0];
            sel_up;
            hdr(1'b1, sd[0], 1'b0);
            rec(a, sd);
            sel_dn;
            shadow_write(int'(a), sd);
            chk("R10 vcom follows header", vcom, sd[0]);
            chk_pix("R4 column 0", int'(a) - 1, 0, shadow[a-1][0]);
            chk_pix("R4 column 95", int'(a) - 1, 95, shadow[a-1][95]);
            chk_pix("R13 zero column", int'(a) - 1, zcol(sd), 1'b0);
            chk_pix("R3 mid column", int'(a) - 1, 47, shadow[a-1][47]);
        end

        // R13: out-of-range row reads white
        chk_pix("R13 row beyond range", 100, 0, 1'b1);

        // R7: hold frame leaves pixels unchanged
        static_frame(1'b1);
        zc = zcol(8'd3);
        chk_pix("R7 pixel kept", 32, zc, 1'b0);
        chk_pix("R7 pixel kept col0", 0, 0, shadow[0][0]);
        chk("R10 vcom from hold frame", vcom, 1'b1);

        // R5: deferred commit through the holding latch
        zc  = zcol(8'd11);
        zc2 = zcol(8'd23);
        sel_up;
        hdr(1'b1, 1'b1, 1'b0);
        rec(7'd12, 8'd11);
        tick(12);
        chk_pix("R5 not yet committed", 11, zc, 1'b1);
        rec(7'd13, 8'd23);
        tick(12);
        chk_pix("R5 committed on next record", 11, zc, 1'b0);
        chk_pix("R5 second line pending", 12, zc2, 1'b1);
        sel_dn;
        shadow_write(12, 8'd11);
        shadow_write(13, 8'd23);
        chk_pix("R5 committed at select fall", 12, zc2, 1'b0);

        // R2: serial clock ignored while select is low
        zc = zcol(8'd61);
        hdr(1'b1, 1'b0, 1'b0);
        rec(7'd20, 8'd61);
        tick(12);
        chk_pix("R2 no write without select", 19, zc, 1'b1);
        chk("R2 no flag without select", addr_err | trunc_err, 1'b0);

        // R8: bad addresses flagged and discarded, later record accepted
        zc = zcol(8'd90);
        sel_up;
        hdr(1'b1, 1'b1, 1'b0);
        rec(7'd0, 8'd14);
        rec(7'd97, 8'd15);
        rec(7'd30, 8'd90);
        sel_dn;
        shadow_write(30, 8'd90);
        chk("R8 addr_err set", addr_err, 1'b1);
        chk_pix("R8 good record after bad", 29, zc, 1'b0);
        chk_pix("R8 row 0 untouched", 0, 0, shadow[0][0]);
        chk_pix("R8 row 95 untouched", 95, 95, shadow[95][95]);
        static_frame(1'b1);
        chk("R8 addr_err cleared by next frame", addr_err, 1'b0);

        // R9: truncated line
        zc = zcol(8'd7);
        sel_up;
        hdr(1'b1, 1'b1, 1'b0);
        rec_part(7'd40, 8'd7, 40);
        sel_dn;
        chk("R9 trunc_err set", trunc_err, 1'b1);
        chk("R9 no addr error", addr_err, 1'b0);
        chk_pix("R9 line discarded", 39, zc, 1'b1);
        static_frame(1'b1);
        chk("R8 trunc_err cleared by next frame", trunc_err, 1'b0);

        // R6: clear all, write bit also set
        sel_up;
        hdr(1'b1, 1'b1, 1'b1);
        sel_dn;
        for (int r = 0; r < 96; r++) shadow[r] = '1;
        chk_pix("R6 cleared row 32", 32, zcol(8'd3), 1'b1);
        chk_pix("R6 cleared row 29", 29, zcol(8'd90), 1'b1);
        chk_pix("R6 cleared row 11", 11, zcol(8'd11), 1'b1);

        // R12: blanking keeps stored data
        zc = zcol(8'd55);
        sel_up;
        hdr(1'b1, 1'b0, 1'b0);
        rec(7'd60, 8'd55);
        sel_dn;
        chk("R10 vcom low from header", vcom, 1'b0);
        disp_en = 1'b0;
        tick(2);
        chk_pix("R12 blanked reads white", 59, zc, 1'b1);
        disp_en = 1'b1;
        tick(2);
        chk_pix("R12 stored data kept", 59, zc, 1'b0);

        // R11: external polarity source
        strap_ext = 1'b1;
        tick(8);
        chk("R11 armed starts low", vcom, 1'b0);
        inv_pulse;
        chk("R11 toggle while select low", vcom, 1'b1);
        sel_up;
        inv_pulse;
        chk("R11 held while select high", vcom, 1'b1);
        sel_dn;
        chk("R11 applied after select fall", vcom, 1'b0);
        static_frame(1'b1);
        chk("R11 header polarity ignored", vcom, 1'b0);
        disp_en = 1'b0;
        tick(2);
        inv_pulse;
        disp_en = 1'b1;
        tick(8);
        chk("R12 pin edge ignored while blanked", vcom, 1'b0);
        inv_pulse;
        chk("R11 toggles again when enabled", vcom, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule